// File: doc/BRIEF.md
# Dual Synthesizer Divider and Lock Detector

This block holds the digital side of two phase-locked loops that share one crystal. Each loop divides the crystal down to a comparison rate with its own programmable reference divider. It divides its oscillator down with a feedback divider. An edge-triggered phase/frequency comparator turns the two divided edges into up and down requests for a charge pump. The first loop has a fixed feedback ratio, 1120 by default, which takes a 280 MHz oscillator down to a 250 kHz comparison rate. The second loop first divides its oscillator by four and then by a 12-bit programmable ratio, so its comparison rate, and with it the frequency step, is set by its reference ratio.

The whole block runs on one fast sampling clock. The crystal and both oscillators arrive as single-cycle tick strobes, one per source edge, and pulse widths are measured in sampling-clock cycles. Each loop has a lock detector. It declares lock after a run of consecutive comparisons in which every correction pulse stayed narrow. The single lock output is high only while both loops report lock. A ratio written on the divider inputs is taken up only at that divider's next terminal count, so a change never cuts a cycle short.

Top module: `dual_synth_lock`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released with no ticks arriving, up1, dn1, up2, dn2 and lock are all low.
- R2: A reference divider with ratio N (N = 0 means 2^REF_W) produces an edge on the Nth crystal tick it counts, and the loop's up output goes high in the cycle after that tick if its down output is low.
- R3: The first loop's feedback divider produces an edge on every MAIN1_RATIO-th vco1 tick, and dn1 goes high in the cycle after that tick if up1 is low.
- R4: The second loop produces a feedback edge on every (PRESCALE x M)-th vco2 tick, where M is the 12-bit main2_div value and 0 means 4096. dn2 goes high in the cycle after that tick if up2 is low.
- R5: A comparator's up and down outputs are never high together. Once both are requested, both read low in the next cycle. Reference and feedback edges in the same cycle produce no pulse at all.
- R6: A ratio change on ref1_div, ref2_div or main2_div takes effect only after the divider's current count reaches its terminal value under the old ratio.
- R7: A comparison is good when its up or down pulse lasts fewer than PULSE_TH cycles. A loop becomes locked after LOCK_CYC consecutive good comparisons. In the cycle after any pulse reaches PULSE_TH cycles, that loop is unlocked and its count restarts.
- R8: lock is high only when both loops are locked; one loop in lock alone leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_tick | input | 1 | One-cycle strobe per crystal edge, shared by both loops |
| vco1_tick | input | 1 | One-cycle strobe per first-loop oscillator edge |
| vco2_tick | input | 1 | One-cycle strobe per second-loop oscillator edge |
| ref1_div | input | REF_W | First-loop reference ratio (0 = 2^REF_W) |
| ref2_div | input | REF_W | Second-loop reference ratio (0 = 2^REF_W) |
| main2_div | input | MAIN2_W | Second-loop ratio after the prescaler (0 = 2^MAIN2_W) |
| up1 | output | 1 | First-loop charge-pump up request |
| dn1 | output | 1 | First-loop charge-pump down request |
| up2 | output | 1 | Second-loop charge-pump up request |
| dn2 | output | 1 | Second-loop charge-pump down request |
| lock | output | 1 | High while both loops are locked |

## Verification
The bench builds the block with a 7-bit reference width, a fixed first-loop ratio of 6 and a lock run of 8 comparisons, and keeps the default prescaler of 4 and pulse threshold of 4. With these values a full comparison period lasts tens of cycles rather than thousands. The zero-means-full-range ratios of both programmable dividers can then be run to their terminal counts. Many random pairs of matched and mismatched ratios, with edge offsets on both sides of the pulse threshold, can each be run long enough to lock or to show that lock never comes.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    localparam int NUM_LOOPS = 2;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_req_t;

endpackage

// File: rtl/dsd_divider.sv
module dsd_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] ratio_i,
    output logic         term_o
);

    typedef struct packed {
        logic         armed;
        logic [W-1:0] ratio;
        logic [W-1:0] cnt;
    } div_state_t;

    div_state_t   s_q, s_d;
    logic [W-1:0] last_idx;

    always_comb begin
        s_d      = s_q;
        term_o   = 1'b0;
        last_idx = s_q.ratio - W'(1);
        if (!s_q.armed) begin
            // first cycle out of reset: take the programmed ratio
            s_d.armed = 1'b1;
            s_d.ratio = ratio_i;
            s_d.cnt   = '0;
        end else if (tick_i) begin
            if (s_q.cnt == last_idx) begin
                term_o    = 1'b1;
                s_d.cnt   = '0;
                s_d.ratio = ratio_i;
            end else begin
                s_d.cnt = s_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/dsd_pfd.sv
module dsd_pfd
    import dsd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_edge_i,
    input  logic      fb_edge_i,
    output pump_req_t pump_o,
    output logic      cmp_done_o
);

    pump_req_t s_q, s_d;
    logic      want_up, want_dn;

    always_comb begin
        want_up    = s_q.up | ref_edge_i;
        want_dn    = s_q.dn | fb_edge_i;
        cmp_done_o = want_up & want_dn;
        s_d.up     = want_up & ~cmp_done_o;
        s_d.dn     = want_dn & ~cmp_done_o;
        pump_o     = s_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/dsd_lockdet.sv
module dsd_lockdet
    import dsd_pkg::*;
#(
    parameter int PULSE_TH = 4,
    parameter int LOCK_CYC = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pump_req_t pump_i,
    input  logic      cmp_done_i,
    output logic      locked_o
);

    localparam int WW = $clog2(PULSE_TH + 1);
    localparam int CW = $clog2(LOCK_CYC + 1);
    localparam logic [WW:0]   TH_X  = (WW + 1)'(PULSE_TH);
    localparam logic [WW-1:0] W_SAT = WW'(PULSE_TH);
    localparam logic [CW-1:0] LC_X  = CW'(LOCK_CYC);

    typedef struct packed {
        logic [WW-1:0] width;
        logic [CW-1:0] good;
    } lk_state_t;

    lk_state_t s_q, s_d;
    logic      active, too_wide;

    always_comb begin
        s_d      = s_q;
        active   = pump_i.up | pump_i.dn;
        too_wide = active && (({1'b0, s_q.width} + (WW + 1)'(1)) >= TH_X);

        if (cmp_done_i)
            s_d.width = '0;
        else if (active && s_q.width != W_SAT)
            s_d.width = s_q.width + WW'(1);

        if (too_wide)
            s_d.good = '0;
        else if (cmp_done_i && s_q.good != LC_X)
            s_d.good = s_q.good + CW'(1);

        locked_o = (s_q.good == LC_X);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/dual_synth_lock.sv
module dual_synth_lock
    import dsd_pkg::*;
#(
    parameter int REF_W       = 10,
    parameter int MAIN1_RATIO = 1120,
    parameter int PRESCALE    = 4,
    parameter int MAIN2_W     = 12,
    parameter int PULSE_TH    = 4,
    parameter int LOCK_CYC    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xtal_tick,
    input  logic               vco1_tick,
    input  logic               vco2_tick,
    input  logic [REF_W-1:0]   ref1_div,
    input  logic [REF_W-1:0]   ref2_div,
    input  logic [MAIN2_W-1:0] main2_div,
    output logic               up1,
    output logic               dn1,
    output logic               up2,
    output logic               dn2,
    output logic               lock
);

    localparam int M1_W  = $clog2(MAIN1_RATIO + 1);
    localparam int PRE_W = $clog2(PRESCALE + 1);

    logic [REF_W-1:0]     ref_ratio [NUM_LOOPS];
    logic [NUM_LOOPS-1:0] ref_edge, fb_edge, cmp_done, loop_locked;
    pump_req_t            pump [NUM_LOOPS];
    logic                 pre_tick;

    assign ref_ratio[0] = ref1_div;
    assign ref_ratio[1] = ref2_div;

    // first loop: fixed feedback ratio
    dsd_divider #(.W(M1_W)) u_main1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (vco1_tick),
        .ratio_i(M1_W'(MAIN1_RATIO)),
        .term_o (fb_edge[0])
    );

    // second loop: prescaler then programmable divider
    if (PRESCALE > 1) begin : g_pre
        dsd_divider #(.W(PRE_W)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (vco2_tick),
            .ratio_i(PRE_W'(PRESCALE)),
            .term_o (pre_tick)
        );
    end else begin : g_nopre
        assign pre_tick = vco2_tick;
    end

    dsd_divider #(.W(MAIN2_W)) u_main2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (pre_tick),
        .ratio_i(main2_div),
        .term_o (fb_edge[1])
    );

    for (genvar gi = 0; gi < NUM_LOOPS; gi++) begin : g_loop
        dsd_divider #(.W(REF_W)) u_ref (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (xtal_tick),
            .ratio_i(ref_ratio[gi]),
            .term_o (ref_edge[gi])
        );

        dsd_pfd u_pfd (
            .clk       (clk),
            .rst_n     (rst_n),
            .ref_edge_i(ref_edge[gi]),
            .fb_edge_i (fb_edge[gi]),
            .pump_o    (pump[gi]),
            .cmp_done_o(cmp_done[gi])
        );

        dsd_lockdet #(.PULSE_TH(PULSE_TH), .LOCK_CYC(LOCK_CYC)) u_lock (
            .clk       (clk),
            .rst_n     (rst_n),
            .pump_i    (pump[gi]),
            .cmp_done_i(cmp_done[gi]),
            .locked_o  (loop_locked[gi])
        );
    end

    assign up1  = pump[0].up;
    assign dn1  = pump[0].dn;
    assign up2  = pump[1].up;
    assign dn2  = pump[1].dn;
    assign lock = &loop_locked;

endmodule

// File: rtl/dual_synth_lock_chk.sv
module dual_synth_lock_chk #(
    parameter int PULSE_TH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic xtal_tick,
    input logic vco1_tick,
    input logic vco2_tick,
    input logic up1,
    input logic dn1,
    input logic up2,
    input logic dn2,
    input logic lock
);

    localparam int RW = $clog2(PULSE_TH + 1) + 1;
    localparam logic [RW-1:0] RUN_LIM = RW'(PULSE_TH - 1);
    localparam logic [RW-1:0] RUN_SAT = RW'(PULSE_TH);

    logic [RW-1:0] run1_q, run2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run1_q <= '0;
            run2_q <= '0;
        end else begin
            run1_q <= (up1 | dn1) ? ((run1_q == RUN_SAT) ? run1_q : run1_q + RW'(1)) : '0;
            run2_q <= (up2 | dn2) ? ((run2_q == RUN_SAT) ? run2_q : run2_q + RW'(1)) : '0;
        end
    end

    AST_PFD1_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(up1 && dn1)); // R5
    AST_PFD2_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(up2 && dn2)); // R5
    AST_UP1_FROM_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up1) |-> $past(xtal_tick)); // R2
    AST_UP2_FROM_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up2) |-> $past(xtal_tick)); // R2
    AST_DN1_FROM_VCO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn1) |-> $past(vco1_tick)); // R3
    AST_DN2_FROM_VCO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn2) |-> $past(vco2_tick)); // R4
    AST_WIDE1_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ((up1 || dn1) && run1_q >= RUN_LIM) |=> !lock); // R7
    AST_WIDE2_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ((up2 || dn2) && run2_q >= RUN_LIM) |=> !lock); // R7

endmodule

bind dual_synth_lock dual_synth_lock_chk #(.PULSE_TH(PULSE_TH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xtal_tick(xtal_tick),
    .vco1_tick(vco1_tick),
    .vco2_tick(vco2_tick),
    .up1      (up1),
    .dn1      (dn1),
    .up2      (up2),
    .dn2      (dn2),
    .lock     (lock)
);

// File: tb/dual_synth_lock_tb.sv
module dual_synth_lock_tb;

    localparam int REF_W       = 7;
    localparam int MAIN1_RATIO = 6;
    localparam int PRESCALE    = 4;
    localparam int MAIN2_W     = 12;
    localparam int PULSE_TH    = 4;
    localparam int LOCK_CYC    = 8;
    localparam int HALF        = 10;   // 20 ns period, 50 MHz

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               xtal_tick = 1'b0, vco1_tick = 1'b0, vco2_tick = 1'b0;
    logic [REF_W-1:0]   ref1_div = '0, ref2_div = '0;
    logic [MAIN2_W-1:0] main2_div = '0;
    logic               up1, dn1, up2, dn2, lock;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    int xp = 1, v1p = 1, v2p = 1, d1 = 0, d2 = 0, g = 0, pulse_cycles = 0;
    bit last_lock = 1'b0;

    always #HALF clk = ~clk;

    dual_synth_lock #(
        .REF_W(REF_W), .MAIN1_RATIO(MAIN1_RATIO), .PRESCALE(PRESCALE),
        .MAIN2_W(MAIN2_W), .PULSE_TH(PULSE_TH), .LOCK_CYC(LOCK_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .vco1_tick(vco1_tick),
        .vco2_tick(vco2_tick), .ref1_div(ref1_div), .ref2_div(ref2_div),
        .main2_div(main2_div), .up1(up1), .dn1(dn1), .up2(up2), .dn2(dn2), .lock(lock)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_lock(bit mis1, bit mis2, int dd1, int dd2);
        return !mis1 && !mis2 && dd1 < PULSE_TH && dd2 < PULSE_TH;
    endfunction

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic do_reset(int r1, int r2, int m2);
        @(negedge clk);
        rst_n = 1'b0;
        xtal_tick = 1'b0; vco1_tick = 1'b0; vco2_tick = 1'b0;
        ref1_div  = REF_W'(r1);
        ref2_div  = REF_W'(r2);
        main2_div = MAIN2_W'(m2);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        g = 0;
        pulse_cycles = 0;
    endtask

    task automatic tick_x(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) xtal_tick = 1'b1;
            @(negedge clk) xtal_tick = 1'b0;
        end
    endtask

    task automatic tick_v1(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) vco1_tick = 1'b1;
            @(negedge clk) vco1_tick = 1'b0;
        end
    endtask

    task automatic tick_v2(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) vco2_tick = 1'b1;
            @(negedge clk) vco2_tick = 1'b0;
        end
    endtask

    // ideal sources: all ticks derived from one phase counter g
    task automatic gen(int n, bit en1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            last_lock = lock;
            if (up1 | dn1 | up2 | dn2) pulse_cycles++;
            xtal_tick = (g % xp == xp - 1);
            vco1_tick = en1 && g >= d1 && ((g - d1) % v1p == v1p - 1);
            vco2_tick = g >= d2 && ((g - d2) % v2p == v2p - 1);
            g++;
        end
    endtask

    task automatic trial(int txp, int tv1p, int tm2, int tv2p, bit mis1, bit mis2,
                         int td1, int td2, string tag);
        int r1, r2, pmax;
        bit expv;
        r1 = MAIN1_RATIO * tv1p / txp + (mis1 ? 3 : 0);
        r2 = PRESCALE * tm2 * tv2p / txp + (mis2 ? 3 : 0);
        pmax = (r1 > r2 ? r1 : r2) * txp;
        xp = txp; v1p = tv1p; v2p = tv2p; d1 = td1; d2 = td2;
        expv = exp_lock(mis1, mis2, td1, td2);
        do_reset(r1, r2, tm2);
        gen(LOCK_CYC * pmax, 1'b1);
        check({tag, " R7 no lock before LOCK_CYC comparisons"}, int'(last_lock), 0);
        gen(5 * pmax, 1'b1);
        check({tag, " R8 lock result"}, int'(last_lock), int'(expv));
        if (expv && td1 == 0 && td2 == 0)
            check({tag, " R5 aligned edges give no pulse"}, pulse_cycles, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2741));

        // R1: reset state
        ref1_div = 7'd5; ref2_div = 7'd5; main2_div = 12'd2;
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", int'({up1, dn1, up2, dn2, lock}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 outputs after release", int'({up1, dn1, up2, dn2, lock}), 0);

        // R2: reference divider counts
        do_reset(9, 7, 3);
        tick_x(6);
        check("R2 up2 before 7th tick", int'(up2), 0);
        tick_x(1);
        check("R2 up2 after 7th tick", int'(up2), 1);
        check("R2 up1 after 7th tick", int'(up1), 0);
        tick_x(1);
        check("R2 up1 after 8th tick", int'(up1), 0);
        tick_x(1);
        check("R2 up1 after 9th tick", int'(up1), 1);

        // R3: fixed feedback ratio
        do_reset(9, 7, 3);
        tick_v1(MAIN1_RATIO - 1);
        check("R3 dn1 before last tick", int'(dn1), 0);
        tick_v1(1);
        check("R3 dn1 after last tick", int'(dn1), 1);

        // R4: prescaler plus programmable ratio, then R5 clear
        do_reset(9, 7, 3);
        tick_v2(PRESCALE * 3 - 1);
        check("R4 dn2 before 12th tick", int'(dn2), 0);
        tick_v2(1);
        check("R4 dn2 after 12th tick", int'(dn2), 1);
        tick_x(6);
        check("R5 dn2 held, up2 low", int'({up2, dn2}), 1);
        tick_x(1);
        check("R5 both cleared", int'({up2, dn2}), 0);

        // R2 boundary: ratio 0 means 2^REF_W
        do_reset(0, 7, 3);
        tick_x((1 << REF_W) - 1);
        check("R2 ratio0 up1 before full count", int'(up1), 0);
        tick_x(1);
        check("R2 ratio0 up1 at full count", int'(up1), 1);

        // R4 boundary: main ratio 0 means 2^MAIN2_W
        do_reset(9, 7, 0);
        tick_v2(PRESCALE * (1 << MAIN2_W) - 1);
        check("R4 ratio0 dn2 before full count", int'(dn2), 0);
        tick_v2(1);
        check("R4 ratio0 dn2 at full count", int'(dn2), 1);

        // R6: ratio change waits for terminal count
        do_reset(5, 7, 3);
        tick_x(2);
        ref1_div = 7'd3;
        tick_x(2);
        check("R6 old ratio still active", int'(up1), 0);
        tick_x(1);
        check("R6 edge on old ratio", int'(up1), 1);
        tick_v1(MAIN1_RATIO);
        check("R5 loop1 cleared", int'({up1, dn1}), 0);
        tick_x(2);
        check("R6 new ratio before edge", int'(up1), 0);
        tick_x(1);
        check("R6 new ratio edge", int'(up1), 1);

        // directed lock cases
        trial(1, 1, 2, 1, 1'b0, 1'b0, 0, 0, "aligned");
        gen(64, 1'b0);
        check("R7 lock lost when vco1 stops", int'(last_lock), 0);
        trial(2, 2, 3, 1, 1'b0, 1'b0, PULSE_TH - 1, 0, "offset below threshold");
        trial(2, 2, 3, 1, 1'b0, 1'b0, PULSE_TH, 0, "offset at threshold");
        trial(1, 1, 2, 1, 1'b0, 1'b0, 0, PULSE_TH, "loop2 wide only");
        trial(1, 2, 2, 1, 1'b0, 1'b1, 0, 0, "loop2 off frequency");
        trial(1, 2, 2, 1, 1'b1, 1'b0, 0, 0, "loop1 off frequency");

        // random lock cases
        for (int t = 0; t < 16; t++) begin
            int rxp, rv1, rm2, rv2, rd1, rd2;
            bit rmis1, rmis2;
            rxp   = 1 + int'($urandom % 2);
            rv1   = 1 + int'($urandom % 4);
            rm2   = 1 + int'($urandom % 8);
            rv2   = 1 + int'($urandom % 3);
            rmis1 = ($urandom % 5) == 0;
            rmis2 = ($urandom % 5) == 0;
            rd1   = int'($urandom % (PULSE_TH + 2));
            rd2   = int'($urandom % imin(PULSE_TH + 2, PRESCALE * rm2 * rv2));
            trial(rxp, rv1, rm2, rv2, rmis1, rmis2, rd1, rd2, $sformatf("random %0d", t));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule